// File: doc/BRIEF.md
# Beam-Timed Register Sequencer

This block is a small coprocessor that runs a list of two-word instructions from memory and uses them to write display registers at chosen raster positions. It reads list words through a request/grant memory port, and it may only request on odd memory slots. Decoded register writes leave through a one-cycle write strobe with a destination address and 16-bit data. The current beam position comes in from outside as an 8-bit vertical count and a 9-bit horizontal count, together with a blitter-finished flag.

There are three instruction kinds. A MOVE writes an immediate value to a register. A WAIT parks the sequencer off the bus until the beam reaches a target. A SKIP suppresses the next MOVE if the beam has already reached a target. Both beam tests are masked greater-or-equal compares on a packed word made of eight vertical bits followed by horizontal bits 8..2. The top vertical bit is always compared, and the test can also require the blitter-finished flag.

Two location inputs supply jump targets. A jump strobe, or the vertical-blank strobe, restarts the list. A write to the blitter register window is refused unless a guard bit is set, and a refused write halts the sequencer until the next restart. The guard bit is cleared by reset and loaded by a MOVE to a control address.

Top module: `beam_listproc`

## Requirements
- R1: After reset the sequencer is halted and raises no memory request until a restart. A restart takes `loc1` when `jmp1` or `vblank` is high, and `loc2` when only `jmp2` is high. Bit 0 of the target is forced to 0, and the next fetch reads from that byte address.
- R2: `mem_req` is high only while `slot_odd` is high. Each granted word advances the fetch address by 2. With `slot_odd` toggling every clock and every request granted, consecutive MOVE writes come 4 cycles apart.
- R3: A first word with bit 0 = 0 is a MOVE. `reg_addr` is `{w1[8:1],1'b0}`, `reg_wdata` is the second word, and `reg_we` pulses on the cycle after the second word is granted.
- R4: A first word with bit 0 = 1 and a second word with bit 0 = 0 is a WAIT. The first word holds target V[7:0] in bits 15..8 and H[8:2] in bits 7..1. The second word holds vertical mask V[6:0] in bits 14..8 and horizontal mask H[8:2] in bits 7..1. The sequencer makes no requests until (beam AND mask) >= (target AND mask) on the packed 15-bit word, and then it resumes fetching.
- R5: Vertical bit 7 has no mask bit and always takes part in the compare.
- R6: A first word with bit 0 = 1 and a second word with bit 0 = 1 is a SKIP. If the beam test holds, the next instruction is fetched but, if it is a MOVE, it is not written. Otherwise that MOVE executes normally.
- R7: Second-word bit 15 = 0 makes a WAIT release, or a SKIP take effect, only while `blit_done` is 1. Bit 15 = 1 ignores `blit_done`.
- R8: The guard bit is 0 after reset. A MOVE to address 0x02E loads it from data bit 1.
- R9: A MOVE to an address in 0x040..0x07E while the guard bit is 0 produces no write. The sequencer then stops making requests until the next restart. Address 0x080 is outside the window.
- R10: A restart while a WAIT is pending abandons the wait and fetches from the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_odd | input | 1 | Current memory slot is odd (requests allowed) |
| mem_req | output | 1 | List fetch request |
| mem_addr | output | 18 | Byte address of the word requested |
| mem_gnt | input | 1 | Grant; `mem_rdata` valid in the same cycle |
| mem_rdata | input | 16 | List word read |
| beam_v | input | 8 | Vertical beam count |
| beam_h | input | 9 | Horizontal beam count |
| blit_done | input | 1 | Blitter-finished flag |
| loc1 | input | 18 | First jump location |
| loc2 | input | 18 | Second jump location |
| jmp1 | input | 1 | Restart strobe at `loc1` |
| jmp2 | input | 1 | Restart strobe at `loc2` |
| vblank | input | 1 | Vertical-blank start strobe (restart at `loc1`) |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 9 | Register write address |
| reg_wdata | output | 16 | Register write data |

## Verification
The fetch address is due on the first cycle after the restart edge. A MOVE write is due exactly one cycle after the grant of its second word. The bench samples just before each rising edge, so it can measure both delays and the 4-cycle spacing of writes against grants it sees itself. WAIT and SKIP outcomes are checked with the beam held still over a window of 20 or more cycles. That window is longer than any fetch-and-write sequence, so the write count at its end is settled, and the expected compare is worked out as a vertical-then-horizontal field comparison.

// File: rtl/blp_pkg.sv
package blp_pkg;
  localparam int WORD_W  = 16;
  localparam int PACK_W  = 15;

  typedef enum logic [1:0] {ST_HALT, ST_FETCH1, ST_FETCH2, ST_WAIT} blp_state_e;

  // packed beam word: V[7:0] then H[8:2]
  function automatic logic [PACK_W-1:0] pack_beam(input logic [7:0] v, input logic [8:0] h);
    return {v, h[8:2]};
  endfunction

  function automatic logic [PACK_W-1:0] target_of(input logic [WORD_W-1:0] w1);
    return {w1[15:8], w1[7:1]};
  endfunction

  // top vertical bit always enabled
  function automatic logic [PACK_W-1:0] mask_of(input logic [WORD_W-1:0] w2);
    return {1'b1, w2[14:8], w2[7:1]};
  endfunction

  function automatic logic beam_reached(input logic [PACK_W-1:0] beam,
                                        input logic [WORD_W-1:0] w1,
                                        input logic [WORD_W-1:0] w2,
                                        input logic blit);
    logic [PACK_W-1:0] m;
    m = mask_of(w2);
    return ((beam & m) >= (target_of(w1) & m)) && (w2[15] || blit);
  endfunction
endpackage

// File: rtl/blp_pc.sv
module blp_pc #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] pc
);
  localparam logic [AW-1:0] STEP_BYTES = AW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc <= '0;
    else if (load)
      pc <= {load_val[AW-1:1], 1'b0};
    else if (step)
      pc <= pc + STEP_BYTES;
  end
endmodule

// File: rtl/blp_cmp.sv
module blp_cmp
  import blp_pkg::*;
(
  input  logic [7:0]        beam_v,
  input  logic [8:0]        beam_h,
  input  logic [WORD_W-1:0] w1,
  input  logic [WORD_W-1:0] w2,
  input  logic              blit_done,
  output logic              hit
);
  logic [PACK_W-1:0] beam_word;
  assign beam_word = pack_beam(beam_v, beam_h);
  assign hit       = beam_reached(beam_word, w1, w2, blit_done);
endmodule

// File: rtl/blp_move_guard.sv
module blp_move_guard #(
  parameter int            RA        = 9,
  parameter logic [RA-1:0] CTRL_ADDR = 9'h02E,
  parameter logic [RA-1:0] PROT_LO   = 9'h040,
  parameter logic [RA-1:0] PROT_HI   = 9'h080
) (
  input  logic [RA-1:0] dest,
  input  logic          danger,
  output logic          allowed,
  output logic          is_ctrl
);
  logic in_prot;

  generate
    if (PROT_HI > PROT_LO) begin : g_prot
      assign in_prot = (dest >= PROT_LO) && (dest < PROT_HI);
    end else begin : g_noprot
      assign in_prot = 1'b0;
    end
  endgenerate

  assign allowed = !in_prot || danger;
  assign is_ctrl = (dest == CTRL_ADDR);
endmodule

// File: rtl/beam_listproc.sv
module beam_listproc
  import blp_pkg::*;
#(
  parameter int            AW        = 18,
  parameter int            RA        = 9,
  parameter logic [RA-1:0] CTRL_ADDR = 9'h02E,
  parameter logic [RA-1:0] PROT_LO   = 9'h040,
  parameter logic [RA-1:0] PROT_HI   = 9'h080
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_odd,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic [15:0]   mem_rdata,
  input  logic [7:0]    beam_v,
  input  logic [8:0]    beam_h,
  input  logic          blit_done,
  input  logic [AW-1:0] loc1,
  input  logic [AW-1:0] loc2,
  input  logic          jmp1,
  input  logic          jmp2,
  input  logic          vblank,
  output logic          reg_we,
  output logic [RA-1:0] reg_addr,
  output logic [15:0]   reg_wdata
);
  blp_state_e  st;
  logic [15:0] ir1, ir2;
  logic        skip_q, danger_q;

  // named events
  logic          restart, fetch_fire, fire_w1, fire_w2, in_wait;
  logic [AW-1:0] restart_target;
  logic          dec_move, dec_skip, dec_wait;
  logic          cmp_hit, guard_ok, guard_ctrl;
  logic          move_commit, halt_trap, wait_release;
  logic [RA-1:0] move_dest;
  logic [15:0]   cmp_w2;

  assign restart        = jmp1 || jmp2 || vblank;
  assign restart_target = (jmp1 || vblank) ? loc1 : loc2;
  assign in_wait        = (st == ST_WAIT);
  assign mem_req        = slot_odd && !restart && (st == ST_FETCH1 || st == ST_FETCH2);
  assign fetch_fire     = mem_req && mem_gnt;
  assign fire_w1        = fetch_fire && (st == ST_FETCH1);
  assign fire_w2        = fetch_fire && (st == ST_FETCH2);

  assign dec_move  = !ir1[0];
  assign dec_skip  = ir1[0] && mem_rdata[0];
  assign dec_wait  = ir1[0] && !mem_rdata[0];
  assign move_dest = {ir1[RA-1:1], 1'b0};
  assign cmp_w2    = in_wait ? ir2 : mem_rdata;

  blp_pc #(.AW(AW)) u_pc (
    .clk(clk), .rst_n(rst_n), .load(restart), .load_val(restart_target),
    .step(fetch_fire), .pc(mem_addr)
  );

  blp_cmp u_cmp (
    .beam_v(beam_v), .beam_h(beam_h), .w1(ir1), .w2(cmp_w2),
    .blit_done(blit_done), .hit(cmp_hit)
  );

  blp_move_guard #(.RA(RA), .CTRL_ADDR(CTRL_ADDR), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_guard (
    .dest(move_dest), .danger(danger_q), .allowed(guard_ok), .is_ctrl(guard_ctrl)
  );

  assign move_commit  = fire_w2 && dec_move && !skip_q && guard_ok;
  assign halt_trap    = fire_w2 && dec_move && !skip_q && !guard_ok;
  assign wait_release = in_wait && cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HALT;
      ir1       <= '0;
      ir2       <= '0;
      skip_q    <= 1'b0;
      danger_q  <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= move_commit;
      if (move_commit) begin
        reg_addr  <= move_dest;
        reg_wdata <= mem_rdata;
        if (guard_ctrl) danger_q <= mem_rdata[1];
      end
      if (restart) begin
        st     <= ST_FETCH1;
        skip_q <= 1'b0;
      end else begin
        case (st)
          ST_FETCH1: if (fire_w1) begin
            ir1 <= mem_rdata;
            st  <= ST_FETCH2;
          end
          ST_FETCH2: if (fire_w2) begin
            if (dec_move) begin
              skip_q <= 1'b0;
              st     <= halt_trap ? ST_HALT : ST_FETCH1;
            end else if (dec_skip) begin
              skip_q <= cmp_hit;
              st     <= ST_FETCH1;
            end else if (dec_wait) begin
              ir2    <= mem_rdata;
              skip_q <= 1'b0;
              st     <= ST_WAIT;
            end
          end
          ST_WAIT: if (wait_release) st <= ST_FETCH1;
          default: st <= ST_HALT;
        endcase
      end
    end
  end
endmodule

// File: rtl/blp_checker.sv
module blp_checker #(
  parameter int            AW      = 18,
  parameter int            RA      = 9,
  parameter logic [RA-1:0] PROT_LO = 9'h040,
  parameter logic [RA-1:0] PROT_HI = 9'h080
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slot_odd,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic          reg_we,
  input logic [RA-1:0] reg_addr,
  input logic          restart,
  input logic [AW-1:0] restart_target,
  input logic          st_wait,
  input logic          danger_q
);
  assert_req_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> slot_odd);

  assert_addr_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[0] == 1'b0));

  assert_restart_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (mem_addr == {$past(restart_target[AW-1:1]), 1'b0}));

  assert_we_after_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(mem_req && mem_gnt));

  assert_quiet_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_wait |-> !mem_req);

  assert_guarded_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr >= PROT_LO && reg_addr < PROT_HI) |-> $past(danger_q));
endmodule

bind beam_listproc blp_checker #(.AW(AW), .RA(RA), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_odd(slot_odd), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .reg_we(reg_we), .reg_addr(reg_addr), .restart(restart),
  .restart_target(restart_target), .st_wait(in_wait), .danger_q(danger_q)
);

// File: tb/tb_beam_listproc.sv
`timescale 1ns/1ps
module tb_beam_listproc;
  logic clk = 1'b0, rst_n = 1'b0, slot_odd = 1'b0;
  logic mem_req, mem_gnt, reg_we;
  logic [17:0] mem_addr, loc1 = '0, loc2 = '0;
  logic [15:0] mem_rdata, reg_wdata;
  logic [8:0]  reg_addr;
  logic [7:0]  beam_v = '0;
  logic [8:0]  beam_h = '0;
  logic blit_done = 1'b0, jmp1 = 1'b0, jmp2 = 1'b0, vblank = 1'b0;

  logic [15:0] mem [0:255];
  int tests = 0, fails = 0;
  int wcount = 0, sample = 0, last_fire = -10, odd_viol = 0, lat_viol = 0;
  logic [24:0] wlog [0:7];
  int          wtime [0:7];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  assign mem_gnt   = mem_req;
  assign mem_rdata = mem[mem_addr[8:1]];

  beam_listproc dut (
    .clk(clk), .rst_n(rst_n), .slot_odd(slot_odd), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .beam_v(beam_v), .beam_h(beam_h),
    .blit_done(blit_done), .loc1(loc1), .loc2(loc2), .jmp1(jmp1), .jmp2(jmp2),
    .vblank(vblank), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
  );

  initial forever begin
    @(negedge clk); #2 slot_odd = ~slot_odd;
  end

  // monitor: samples just before each rising edge
  initial forever begin
    @(negedge clk); #8;
    sample++;
    if (mem_req && !slot_odd) odd_viol++;
    if (reg_we) begin
      if (sample - last_fire != 1) lat_viol++;
      if (wcount < 8) begin
        wlog[wcount]  = {reg_addr, reg_wdata};
        wtime[wcount] = sample;
      end
      wcount++;
    end
    if (mem_req && mem_gnt && dut.u_pc.pc[0] == 1'b0) last_fire = sample;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_move(input int idx, input logic [8:0] dest, input logic [15:0] data);
    mem[idx]   = {7'b0, dest[8:1], 1'b0};
    mem[idx+1] = data;
  endtask

  task automatic put_cmp(input int idx, input logic [7:0] v, input logic [8:0] h,
                         input logic [6:0] vm, input logic [6:0] hm, input logic bfd, input logic skp);
    mem[idx]   = {v, h[8:2], 1'b1};
    mem[idx+1] = {bfd, vm, hm, skp};
  endtask

  task automatic put_end(input int idx);
    mem[idx] = 16'hFFFF; mem[idx+1] = 16'hFFFE;
  endtask

  task automatic go(input int which, input logic [17:0] loc);
    @(negedge clk); #2;
    wcount = 0;
    if (which == 2) begin loc2 = loc; jmp2 = 1'b1; end
    else if (which == 3) begin loc1 = loc; vblank = 1'b1; end
    else begin loc1 = loc; jmp1 = 1'b1; end
    @(negedge clk); #2;
    jmp1 = 1'b0; jmp2 = 1'b0; vblank = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic reached(input logic [7:0] tv, input logic [8:0] th, input logic [6:0] vm,
                                   input logic [6:0] hm, input logic [7:0] bv, input logic [8:0] bh);
    int a, b, c, d;
    a = int'(bv & {1'b1, vm});
    b = int'(tv & {1'b1, vm});
    c = int'(bh[8:2] & hm);
    d = int'(th[8:2] & hm);
    return (a > b) || (a == b && c >= d);
  endfunction

  initial begin
    for (int i = 0; i < 256; i += 2) begin mem[i] = 16'hFFFF; mem[i+1] = 16'hFFFE; end
    // list A at 0x10
    put_move(8, 9'h180, 16'h0123); put_move(10, 9'h1FE, 16'hA5A5); put_end(12);
    // list B at 0x40
    put_move(32, 9'h182, 16'h0002); put_end(34);
    // protected list at 0x60
    put_move(48, 9'h040, 16'h1111); put_move(50, 9'h180, 16'h2222); put_end(52);
    // guard set/clear list at 0x80
    put_move(64, 9'h02E, 16'h0002); put_move(66, 9'h040, 16'h3333);
    put_move(68, 9'h02E, 16'h0000); put_end(70);
    // boundary lists at 0x90, 0x98
    put_move(72, 9'h07E, 16'h7777); put_end(74);
    put_move(76, 9'h080, 16'h8888); put_end(78);

    run(3); #2 rst_n = 1'b1;
    // R1 reset state
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin @(negedge clk); if (mem_req) seen++; end
      chk("R1 no request after reset", seen, 0);
      chk("R1 no write after reset", wcount, 0);
    end

    // R1/R2/R3 basic list, odd location rounded down
    go(1, 18'h11);
    chk("R1 fetch address after jmp1", mem_addr, 18'h10);
    run(20);
    chk("R3 write count", wcount, 2);
    chk("R3 first write", wlog[0], {9'h180, 16'h0123});
    chk("R3 second write", wlog[1], {9'h1FE, 16'hA5A5});
    chk("R2 write spacing", wtime[1] - wtime[0], 4);
    chk("R3 write one cycle after grant", lat_viol, 0);

    go(2, 18'h40);
    chk("R1 fetch address after jmp2", mem_addr, 18'h40);
    run(16);
    chk("R1 jmp2 list write", wlog[0], {9'h182, 16'h0002});

    go(3, 18'h10);
    run(16);
    chk("R1 vblank restarts at loc1", wlog[0], {9'h180, 16'h0123});

    // R9 protected write halts, R8 guard clear after reset
    go(2, 18'h60);
    run(20);
    chk("R9 refused write count", wcount, 0);
    chk("R9 halted no request", mem_req, 1'b0);
    go(2, 18'h90); run(16);
    chk("R9 0x07E refused", wcount, 0);
    go(2, 18'h98); run(16);
    chk("R9 0x080 allowed", wlog[0], {9'h080, 16'h8888});
    go(2, 18'h80); run(24);
    chk("R8 guard set allows write count", wcount, 3);
    chk("R8 guarded write data", wlog[1], {9'h040, 16'h3333});
    go(2, 18'h60); run(20);
    chk("R8 guard cleared again", wcount, 0);

    // WAIT list at 0xC0: cmp, move, end
    put_move(98, 9'h180, 16'hBEEF); put_end(100);
    // R4 directed release
    put_cmp(96, 8'h40, 9'h020, 7'h7F, 7'h7F, 1'b1, 1'b0);
    beam_v = 8'h30; beam_h = 9'h000;
    go(2, 18'hC0); run(20);
    chk("R4 wait holds", wcount, 0);
    chk("R4 no request while waiting", mem_req, 1'b0);
    #2 beam_v = 8'h40; beam_h = 9'h020;
    run(16);
    chk("R4 wait releases", wlog[0], {9'h180, 16'hBEEF});
    // R5 top vertical bit unmaskable
    put_cmp(96, 8'h80, 9'h000, 7'h00, 7'h00, 1'b1, 1'b0);
    beam_v = 8'h7F; beam_h = 9'h1FC;
    go(2, 18'hC0); run(20);
    chk("R5 v7 below target holds", wcount, 0);
    go(2, 18'hC0); #2 beam_v = 8'h81; run(20);
    chk("R5 v7 reached releases", wcount, 1);
    // R7 blitter flag
    put_cmp(96, 8'h10, 9'h000, 7'h7F, 7'h7F, 1'b0, 1'b0);
    beam_v = 8'h20; blit_done = 1'b0;
    go(2, 18'hC0); run(20);
    chk("R7 waits for blitter", wcount, 0);
    #2 blit_done = 1'b1; run(16);
    chk("R7 releases on blitter", wcount, 1);

    // R4/R5/R7 sweep
    for (int it = 0; it < 48; it++) begin
      logic [7:0] tv, bv; logic [8:0] th, bh; logic [6:0] vm, hm; logic bfd, bl, e;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; tv = lfsr[7:0]; th = {lfsr[15:8], 1'b0};
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; vm = lfsr[6:0]; hm = lfsr[13:7]; bfd = lfsr[14]; bl = lfsr[15];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; bv = (lfsr[7:0] == 8'hFF) ? 8'hFE : lfsr[7:0]; bh = {lfsr[15:8], 1'b1};
      put_cmp(96, tv, th, vm, hm, bfd, 1'b0);
      beam_v = bv; beam_h = bh; blit_done = bl;
      e = reached(tv, th, vm, hm, bv, bh) && (bfd || bl);
      go(2, 18'hC0); run(20);
      chk("R4 sweep wait outcome", wcount, e ? 1 : 0);
    end

    // R6 SKIP list at 0x100
    put_move(130, 9'h180, 16'hAAAA); put_move(132, 9'h182, 16'h5555); put_end(134);
    for (int it = 0; it < 24; it++) begin
      logic [7:0] tv, bv; logic [8:0] th, bh; logic [6:0] vm, hm; logic bfd, bl, e;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; tv = lfsr[7:0]; th = {lfsr[15:8], 1'b0};
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; vm = lfsr[6:0]; hm = lfsr[13:7]; bfd = lfsr[14]; bl = lfsr[15];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; bv = lfsr[7:0] & 8'hFE; bh = {lfsr[15:8], 1'b0};
      put_cmp(128, tv, th, vm, hm, bfd, 1'b1);
      beam_v = bv; beam_h = bh; blit_done = bl;
      e = reached(tv, th, vm, hm, bv, bh) && (bfd || bl);
      go(2, 18'h100); run(24);
      chk("R6 skip write count", wcount, e ? 1 : 2);
      chk("R6 last write", wlog[e ? 0 : 1], {9'h182, 16'h5555});
    end

    // R10 restart during wait
    put_cmp(96, 8'hF0, 9'h000, 7'h7F, 7'h7F, 1'b1, 1'b0);
    beam_v = 8'h00;
    go(2, 18'hC0); run(12);
    chk("R10 parked in wait", wcount, 0);
    go(1, 18'h10); run(20);
    chk("R10 restart abandons wait", wcount, 2);
    chk("R2 requests only in odd slots", odd_viol, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule